// File: doc/BRIEF.md
# Strided One-Dimensional Finite-Difference Stencil Engine

This engine runs a symmetric nine-point finite-difference stencil along rows of a three-dimensional grid kept in a word-addressed memory. A row is a run of `cfg_row_len` elements spaced `cfg_stride` words apart, and consecutive rows start `cfg_row_pitch` words apart. The stride selects the direction. A stride of 1 walks x, a stride of nx walks y, and a stride of nx·ny walks z. The four elements at each end of a row form a halo: they are read as stencil inputs, but no result is written for them.

There are two modes. In fresh mode, each interior result is the sum of the centre coefficient times the centre sample, the four symmetric tap pairs, and a local potential sample times the centre sample. The result is written to the target array. In update mode, the centre term is dropped, leaving eight taps, and the sum is added to the word already held at the target position. Update mode is a read-modify-write. Samples and coefficients are signed 16-bit values. Sums are kept in a 40-bit accumulator and saturate to signed 32 bits.

A nine-entry shift-register window holds the most recent source samples, so each source element is fetched once per row. The controller has seven states:
- IDLE waits for `start`, latches the configuration and goes to FILL.
- FILL issues eight leading source reads and then goes to LOAD.
- LOAD reads the next leading sample and goes to AUX.
- AUX reads the potential word (fresh mode) or the old target word (update mode) and goes to CALC.
- CALC registers the saturated result and goes to WRITE.
- WRITE stores the result. It then goes to LOAD for the next output, to FILL for the next row, or to DONE after the last output of the last row.
- DONE pulses `done` and returns to IDLE.

Top module: `fd_stencil_engine`

## Requirements
- R1: After reset, and at any time reset is applied, `busy`, `done`, `mem_en` and `mem_we` are low.
- R2: `start` is taken only in IDLE, where all configuration inputs are latched. A `start` pulse or a configuration change during a job has no effect on that job's addresses or results, and no new job follows.
- R3: For each row, the engine issues exactly `cfg_row_len` source reads, so each source element of the row is fetched once. A source sample is the signed low 16 bits of its memory word, and the upper 16 bits are ignored.
- R4: Only row positions 4 to `cfg_row_len`-5 are written, so a job makes `cfg_rows`·(`cfg_row_len`-8) writes. The halo positions of the target array keep their previous contents.
- R5: Element i of row r is at address base + r·`cfg_row_pitch` + i·`cfg_stride` (modulo 2^AW). This rule applies to the source, potential and target arrays.
- R6: In fresh mode (`cfg_update`=0), the result is c0·x0 + v·x0 + Σ(k=1..4) ck·(x−k + x+k). Here v is the signed low 16 bits of the potential word at the same position, and ck sits at `cfg_coef[16k+15:16k]`. No target reads are made.
- R7: In update mode (`cfg_update`=1), the result is the old signed 32-bit target word plus Σ(k=1..4) ck·(x−k + x+k). The engine reads the target once per output, and c0 and the potential array are not used.
- R8: A sum above 2^31−1 is written as 0x7FFFFFFF, and a sum below −2^31 is written as 0x80000000.
- R9: `done` is high for exactly one cycle, the cycle after the last target write. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and low otherwise.
- R10: Memory read data is taken one cycle after the request. `mem_we` is never high without `mem_en`, writes never occur in two consecutive cycles, and there is no memory access while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (taken in IDLE only) |
| cfg_update | input | 1 | 0 = fresh write with centre and potential, 1 = accumulate into target |
| cfg_src_base | input | AW | Source array base address |
| cfg_pot_base | input | AW | Potential array base address |
| cfg_dst_base | input | AW | Target array base address |
| cfg_stride | input | AW | Address step between elements of a row |
| cfg_row_pitch | input | AW | Address step between row starts |
| cfg_row_len | input | LW | Elements per row including both halos (at least 9) |
| cfg_rows | input | LW | Number of rows (at least 1) |
| cfg_coef | input | 5·SW | Coefficients c0..c4, with ck in slice k |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | OW | Write data |
| mem_rdata | input | OW | Read data, valid the cycle after a read request |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle `done` pulse and its coincidence with `busy`;
- the write strobe always appearing with an enable;
- the absence of back-to-back writes and of memory traffic while idle;
- that the number of writes seen at `done` equals rows times interior length.

The arithmetic can only be shown by the bench's scenarios, which compare every target word of a job with a value computed from the memory image. Those scenarios cover:
- the fresh and update formulas in each of the three stride directions;
- saturation in both directions;
- untouched halos;
- per-region read counts;
- that a second `start` with altered configuration mid-job is ignored.

// File: rtl/fd_pkg.sv
package fd_pkg;
    localparam int TAPS = 9;
    localparam int HALF = (TAPS - 1) / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_LOAD,
        ST_AUX,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } fd_state_t;
endpackage

// File: rtl/fd_addr.sv
module fd_addr #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] row_off,
    input  logic [AW-1:0] stride,
    input  logic [LW-1:0] idx,
    output logic [AW-1:0] addr
);
    // element address inside a strided row, wrapping modulo 2^AW
    assign addr = base + row_off + AW'(idx) * stride;
endmodule

// File: rtl/fd_window.sv
module fd_window #(
    parameter int SW   = 16,
    parameter int TAPS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [SW-1:0]     din,
    output logic [TAPS*SW-1:0] win
);
    logic [SW-1:0] taps_q [TAPS];

    // oldest sample in slot 0, newest enters at the top slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < TAPS; t++) taps_q[t] <= '0;
        end else if (shift) begin
            for (int t = 0; t < TAPS - 1; t++) taps_q[t] <= taps_q[t+1];
            taps_q[TAPS-1] <= din;
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_flat
        assign win[g*SW +: SW] = taps_q[g];
    end
endmodule

// File: rtl/fd_mac.sv
module fd_mac
    import fd_pkg::*;
#(
    parameter int SW   = 16,
    parameter int OW   = 32,
    parameter int ACCW = 40
) (
    input  logic [TAPS*SW-1:0]     win,
    input  logic [(HALF+1)*SW-1:0] coef,
    input  logic                   accum,
    input  logic [OW-1:0]          aux,
    output logic [OW-1:0]          result
);
    localparam logic signed [ACCW-1:0] SAT_HI = {{(ACCW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] SAT_LO = {{(ACCW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [SW-1:0]   s_lo, s_hi, ck, ctr, pot;
    logic signed [SW:0]     pair;
    logic signed [OW-1:0]   tgt;
    logic signed [ACCW-1:0] acc;

    always_comb begin
        acc  = '0;
        s_lo = '0;
        s_hi = '0;
        pair = '0;
        ck   = '0;
        for (int k = 1; k <= HALF; k++) begin
            s_lo = win[(HALF-k)*SW +: SW];
            s_hi = win[(HALF+k)*SW +: SW];
            ck   = coef[k*SW +: SW];
            pair = {s_lo[SW-1], s_lo} + {s_hi[SW-1], s_hi};
            acc  = acc + ACCW'(pair) * ACCW'(ck);
        end
        ctr = win[HALF*SW +: SW];
        pot = aux[SW-1:0];
        tgt = aux;
        ck  = coef[SW-1:0];
        if (accum) acc = acc + ACCW'(tgt);
        else       acc = acc + ACCW'(ctr) * ACCW'(ck) + ACCW'(ctr) * ACCW'(pot);
        if (acc > SAT_HI)      result = SAT_HI[OW-1:0];
        else if (acc < SAT_LO) result = SAT_LO[OW-1:0];
        else                   result = acc[OW-1:0];
    end
endmodule

// File: rtl/fd_stencil_engine.sv
module fd_stencil_engine
    import fd_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LW   = 8,
    parameter int SW   = 16,
    parameter int OW   = 32,
    parameter int ACCW = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cfg_update,
    input  logic [AW-1:0]          cfg_src_base,
    input  logic [AW-1:0]          cfg_pot_base,
    input  logic [AW-1:0]          cfg_dst_base,
    input  logic [AW-1:0]          cfg_stride,
    input  logic [AW-1:0]          cfg_row_pitch,
    input  logic [LW-1:0]          cfg_row_len,
    input  logic [LW-1:0]          cfg_rows,
    input  logic [(HALF+1)*SW-1:0] cfg_coef,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [OW-1:0]          mem_wdata,
    input  logic [OW-1:0]          mem_rdata
);
    localparam int CW     = (HALF + 1) * SW;
    localparam int FILL_N = TAPS - 1;

    fd_state_t state, state_nx;

    logic              upd_q;
    logic [AW-1:0]     src_q, pot_q, dst_q, stride_q, pitch_q, row_off;
    logic [LW-1:0]     len_q, rows_q, row_cnt, fetch_idx, out_idx;
    logic [CW-1:0]     coef_q;
    logic [OW-1:0]     result_q, mac_out;
    logic              cap_q;
    logic [TAPS*SW-1:0] win;
    logic [AW-1:0]     sel_base;
    logic [LW-1:0]     sel_idx;
    logic              last_out, last_row;

    assign last_out = (out_idx == len_q - LW'(HALF + 1));
    assign last_row = (row_cnt == rows_q - LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_FILL;
            ST_FILL:  if (fetch_idx == LW'(FILL_N - 1)) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_AUX;
            ST_AUX:   state_nx = ST_CALC;
            ST_CALC:  state_nx = ST_WRITE;
            ST_WRITE: begin
                if (!last_out)     state_nx = ST_LOAD;
                else if (last_row) state_nx = ST_DONE;
                else               state_nx = ST_FILL;
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // configuration, counters and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;      src_q <= '0;     pot_q <= '0;    dst_q <= '0;
            stride_q <= '0;     pitch_q <= '0;   len_q <= '0;    rows_q <= '0;
            coef_q <= '0;       row_off <= '0;   row_cnt <= '0;  fetch_idx <= '0;
            out_idx <= '0;      result_q <= '0;  cap_q <= 1'b0;
        end else begin
            cap_q <= (state == ST_FILL) || (state == ST_LOAD);
            unique case (state)
                ST_IDLE: if (start) begin
                    upd_q <= cfg_update;    src_q <= cfg_src_base;
                    pot_q <= cfg_pot_base;  dst_q <= cfg_dst_base;
                    stride_q <= cfg_stride; pitch_q <= cfg_row_pitch;
                    len_q <= cfg_row_len;   rows_q <= cfg_rows;
                    coef_q <= cfg_coef;     row_off <= '0;
                    row_cnt <= '0;          fetch_idx <= '0;
                    out_idx <= LW'(HALF);
                end
                ST_FILL, ST_LOAD: fetch_idx <= fetch_idx + LW'(1);
                ST_CALC: result_q <= mac_out;
                ST_WRITE: begin
                    if (!last_out) begin
                        out_idx <= out_idx + LW'(1);
                    end else if (!last_row) begin
                        row_cnt   <= row_cnt + LW'(1);
                        row_off   <= row_off + pitch_q;
                        fetch_idx <= '0;
                        out_idx   <= LW'(HALF);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        sel_base  = dst_q;
        sel_idx   = out_idx;
        mem_wdata = result_q;
        unique case (state)
            ST_FILL, ST_LOAD: begin
                mem_en   = 1'b1;
                sel_base = src_q;
                sel_idx  = fetch_idx;
            end
            ST_AUX: begin
                mem_en   = 1'b1;
                sel_base = upd_q ? dst_q : pot_q;
            end
            ST_WRITE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            default: ;
        endcase
    end

    fd_addr #(.AW(AW), .LW(LW)) u_addr (
        .base(sel_base), .row_off(row_off), .stride(stride_q),
        .idx(sel_idx), .addr(mem_addr)
    );

    fd_window #(.SW(SW), .TAPS(TAPS)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(cap_q),
        .din(mem_rdata[SW-1:0]), .win(win)
    );

    fd_mac #(.SW(SW), .OW(OW), .ACCW(ACCW)) u_mac (
        .win(win), .coef(coef_q), .accum(upd_q),
        .aux(mem_rdata), .result(mac_out)
    );
endmodule

// File: rtl/fd_stencil_checker.sv
module fd_stencil_checker #(
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_en,
    input logic          mem_we,
    input logic [LW-1:0] cfg_row_len,
    input logic [LW-1:0] cfg_rows
);
    logic [2*LW-1:0] wr_cnt, wr_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            wr_exp <= '0;
        end else if (start && !busy) begin
            wr_cnt <= '0;
            wr_exp <= {{LW{1'b0}}, cfg_rows} * ({{LW{1'b0}}, cfg_row_len} - (2*LW)'(8));
        end else if (mem_we) begin
            wr_cnt <= wr_cnt + (2*LW)'(1);
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    p_done_busy_r9:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
    p_we_en_r10:     assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en);
    p_we_gap_r10:    assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_en);
    p_write_total_r4: assert property (@(posedge clk) disable iff (!rst_n) done |-> (wr_cnt == wr_exp));
endmodule

bind fd_stencil_engine fd_stencil_checker #(.LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .cfg_row_len(cfg_row_len), .cfg_rows(cfg_rows)
);

// File: tb/fd_stencil_engine_tb.sv
module fd_stencil_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;
    localparam int SRC_BASE   = 0;
    localparam int POT_BASE   = 1300;
    localparam int DST_BASE   = 2600;

    typedef struct packed {
        logic               mode;
        logic [15:0]        stride;
        logic [15:0]        pitch;
        logic [7:0]         len;
        logic [7:0]         rows;
        logic signed [15:0] c0, c1, c2, c3, c4;
        logic [1:0]         kind;
        logic [7:0]         seed;
    } job_t;

    // grid nx=12, ny=10, nz=10: x stride 1, y stride 12, z stride 120
    localparam int NJOBS = 7;
    localparam job_t JOBS [NJOBS] = '{
        '{1'b0, 16'd1,   16'd12, 8'd12, 8'd10, -16'sd20, 16'sd8, -16'sd3, 16'sd2, -16'sd1, 2'd0, 8'd1},
        '{1'b1, 16'd12,  16'd1,  8'd10, 8'd12, -16'sd20, 16'sd8, -16'sd3, 16'sd2, -16'sd1, 2'd0, 8'd2},
        '{1'b1, 16'd120, 16'd1,  8'd10, 8'd12,  16'sd5, -16'sd9, 16'sd4, -16'sd7, 16'sd3,  2'd0, 8'd3},
        '{1'b0, 16'd1,   16'd12, 8'd9,  8'd5,   16'sd11, 16'sd6, 16'sd1, -16'sd2, 16'sd9,  2'd0, 8'd4},
        '{1'b0, 16'd1,   16'd12, 8'd12, 8'd2,   16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 2'd1, 8'd5},
        '{1'b1, 16'd1,   16'd12, 8'd12, 8'd2,   16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 2'd2, 8'd6},
        '{1'b0, 16'd120, 16'd1,  8'd10, 8'd12, -16'sd300, -16'sd40, 16'sd25, -16'sd13, 16'sd7, 2'd0, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_update = 1'b0;
    logic [15:0] cfg_src_base = '0, cfg_pot_base = '0, cfg_dst_base = '0;
    logic [15:0] cfg_stride = '0, cfg_row_pitch = '0;
    logic [7:0]  cfg_row_len = '0, cfg_rows = '0;
    logic [79:0] cfg_coef = '0;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [MEM_WORDS];
    logic        fill_req = 1'b0;
    int          fill_kind = 0;
    int          fill_seed = 0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fd_stencil_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_update(cfg_update),
        .cfg_src_base(cfg_src_base), .cfg_pot_base(cfg_pot_base), .cfg_dst_base(cfg_dst_base),
        .cfg_stride(cfg_stride), .cfg_row_pitch(cfg_row_pitch), .cfg_row_len(cfg_row_len),
        .cfg_rows(cfg_rows), .cfg_coef(cfg_coef), .busy(busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory image: upper halves of source and potential words carry junk (R3, R6)
    function automatic logic [31:0] gen(int a, int kind, int seed);
        int h;
        int v;
        h = (a * 7919 + seed * 104729 + 17) % 65521;
        if (a < POT_BASE) begin
            if (kind == 1)      v = 32767;
            else if (kind == 2) v = -32768;
            else                v = (h % 401) - 200;
            return {h[15:0] ^ 16'h5a5a, v[15:0]};
        end else if (a < DST_BASE) begin
            v = (h % 61) - 30;
            return {h[7:0], 8'h3c, v[15:0]};
        end
        v = (h * 31) % 2000001 - 1000000;
        return v;
    endfunction

    function automatic longint low16(logic [31:0] w);
        logic signed [15:0] s;
        s = w[15:0];
        return longint'(s);
    endfunction

    function automatic longint golden(job_t j, int r, int i);
        longint acc, x0;
        longint cf [5];
        int off;
        int st;
        logic signed [31:0] old;
        st = int'(j.stride);
        off = r * int'(j.pitch) + i * st;
        cf[0] = longint'(j.c0); cf[1] = longint'(j.c1); cf[2] = longint'(j.c2);
        cf[3] = longint'(j.c3); cf[4] = longint'(j.c4);
        acc = 0;
        for (int k = 1; k <= 4; k++)
            acc += cf[k] * (low16(gen(SRC_BASE + off - k * st, j.kind, j.seed)) +
                            low16(gen(SRC_BASE + off + k * st, j.kind, j.seed)));
        x0 = low16(gen(SRC_BASE + off, j.kind, j.seed));
        if (j.mode) begin
            old = gen(DST_BASE + off, j.kind, j.seed);
            acc += longint'(old);
        end else begin
            acc += cf[0] * x0 + low16(gen(POT_BASE + off, j.kind, j.seed)) * x0;
        end
        if (acc > 64'sd2147483647)  acc = 64'sd2147483647;
        if (acc < -64'sd2147483648) acc = -64'sd2147483648;
        return acc;
    endfunction

    always @(posedge clk) begin
        if (fill_req) begin
            for (int a = 0; a < MEM_WORDS; a++) mem[a] <= gen(a, fill_kind, fill_seed);
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_cfg(input job_t j);
        cfg_update    = j.mode;
        cfg_stride    = j.stride;
        cfg_row_pitch = j.pitch;
        cfg_row_len   = j.len;
        cfg_rows      = j.rows;
        cfg_coef      = {j.c4, j.c3, j.c2, j.c1, j.c0};
        cfg_src_base  = 16'(SRC_BASE);
        cfg_pot_base  = 16'(POT_BASE);
        cfg_dst_base  = 16'(DST_BASE);
    endtask

    task automatic load_image(input job_t j);
        fill_kind = int'(j.kind);
        fill_seed = int'(j.seed);
        @(negedge clk) fill_req = 1'b1;
        @(negedge clk) fill_req = 1'b0;
    endtask

    task automatic run_job(input job_t j, input bit disturb);
        int cyc = 0, wr = 0, rs = 0, rp = 0, rd = 0;
        int last_we = -1, done_cyc = -1, done_n = 0;
        int busy_gap = 0, post_busy = 0, we_no_en = 0, we_pair = 0;
        bit seen = 0, prev_we = 0;
        int rows = int'(j.rows);
        int len = int'(j.len);
        string req;
        load_image(j);
        @(negedge clk);
        drive_cfg(j);
        start = 1'b1;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (mem_en && !mem_we) begin
                if (int'(mem_addr) < POT_BASE)      rs++;
                else if (int'(mem_addr) < DST_BASE) rp++;
                else                                rd++;
            end
            if (mem_we) begin
                wr++;
                last_we = cyc;
                if (!mem_en) we_no_en++;
                if (prev_we) we_pair++;
            end
            prev_we = mem_we;
            if (!seen) begin
                if (!busy) busy_gap++;
            end else if (busy || mem_en) begin
                post_busy++;
            end
            if (done) begin
                done_n++;
                done_cyc = cyc;
                seen = 1;
            end
            start = 1'b0;
            if (disturb && cyc == 20) begin
                // R2: second start with a different configuration mid-job
                start = 1'b1;
                drive_cfg(JOBS[1]);
                cfg_dst_base = 16'd5;
            end
            if (seen && cyc >= done_cyc + 10) break;
        end
        check(seen, "R9", "job completion seen", longint'(seen), 1);
        check(done_n == 1, "R9", "done pulse count", done_n, 1);
        check(done_cyc == last_we + 1, "R9", "done cycle after last write", done_cyc, last_we + 1);
        check(busy_gap == 0, "R9", "busy low during job", busy_gap, 0);
        check(post_busy == 0, "R2", "activity after done", post_busy, 0);
        check(rs == rows * len, "R3", "source reads", rs, rows * len);
        check(wr == rows * (len - 8), "R4", "write count", wr, rows * (len - 8));
        check(rp == (j.mode ? 0 : rows * (len - 8)), "R6", "potential reads", rp,
              j.mode ? 0 : rows * (len - 8));
        check(rd == (j.mode ? rows * (len - 8) : 0), "R7", "target reads", rd,
              j.mode ? rows * (len - 8) : 0);
        check(we_no_en == 0 && we_pair == 0, "R10", "write strobe rules", we_no_en + we_pair, 0);
        req = j.mode ? "R5 R7" : "R5 R6";
        if (j.kind != 0) req = {req, " R8"};
        for (int r = 0; r < rows; r++) begin
            for (int i = 0; i < len; i++) begin
                int a;
                longint got, exp;
                logic signed [31:0] w;
                a = DST_BASE + r * int'(j.pitch) + i * int'(j.stride);
                w = mem[a];
                got = longint'(w);
                if (i < 4 || i > len - 5) begin
                    w = gen(a, j.kind, j.seed);
                    exp = longint'(w);
                    check(got == exp, "R4", $sformatf("halo r=%0d i=%0d", r, i), got, exp);
                end else begin
                    exp = golden(j, r, i);
                    check(got == exp, req, $sformatf("result r=%0d i=%0d", r, i), got, exp);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_en && !mem_we, "R1", "reset outputs",
              {busy, done, mem_en, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_en, "R1", "idle after reset", {busy, done, mem_en}, 0);

        // table of jobs: directions, both modes, minimum row, saturation
        for (int n = 0; n < NJOBS; n++) run_job(JOBS[n], 1'b0);

        // R2: start and configuration changes during a job are ignored
        run_job(JOBS[0], 1'b1);

        // R1: reset applied mid-job
        load_image(JOBS[2]);
        @(negedge clk);
        drive_cfg(JOBS[2]);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_en && !mem_we, "R1", "reset mid-job",
              {busy, done, mem_en, mem_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !mem_en, "R1", "idle after mid-job reset", {busy, mem_en}, 0);

        // job after reset still correct
        run_job(JOBS[3], 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule